// File: doc/BRIEF.md
# Bit-Plane Pixel Serializer

This block produces a serial colour pixel stream from three separate one-bit-per-pixel image planes for red, green and blue. Each plane is fetched a byte at a time. One byte from every plane is captured into its own parallel-load shift register, and the three registers run in lockstep. A bit leaves each register on every pixel clock, so each pixel can take one of eight colours.

A display timing generator supplies a display-enable level and a line-start pulse. While display-enable is high, the block raises a read request once every eight pixel clocks and drives a byte address with it. The plane memories return their three bytes on the following clock. The fetch is issued ahead of the group it feeds, so a memory with one cycle of read latency never stalls the stream. Outside the enable window the colour output is held dark and no fetches are made. The memories and the timing generator sit outside this block.

Top module: `bitplane_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `rgb` is 0 and `rd_req` is 0.
- R2: A request is raised in the first cycle of display-enable, and then every BYTE_W (default 8) cycles while display-enable stays high. At most H_ACTIVE/BYTE_W (80) requests are made per line. Requests beyond that count are never issued, even when display-enable stays high for longer.
- R3: Each request carries the address row*(H_ACTIVE/BYTE_W) + group. Here group is the index of the request within the line, starting at 0, and row is the current visible row.
- R4: The pixel with index k in a line is the k-th cycle of display-enable, counting from 0. It appears on `rgb` exactly two cycles after that cycle. Each plane bit is bit (BYTE_W-1 - k mod BYTE_W) of the byte returned for group k/BYTE_W, so the most significant bit is the leftmost pixel. The bits map as `rgb[2]` = red, `rgb[1]` = green and `rgb[0]` = blue.
- R5: The three planes are captured in the same cycle and shift together. With differing data on each plane, every pixel carries the correct bit of all three planes at once.
- R6: `rgb` is 0 in every cycle that is not two cycles after a display-enable cycle. This includes pixels past the H_ACTIVE-th on an over-long line. No request is made while display-enable is low.
- R7: The row advances by one at a line-start pulse only when display-enable was high at some point since the previous line-start. A line with no visible pixels leaves the row unchanged. After row V_ACTIVE-1 the row wraps to 0.
- R8: A line-start pulse restarts the group count at 0. A line cut short by display-enable falling early is followed by a line that fetches from group 0 of the next row.
- R9: Plane bytes of all zeros give `rgb` = 3'b000 (black), and all ones give `rgb` = 3'b111 (white).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| de | input | 1 | Display-enable level from the timing generator |
| line_start | input | 1 | One-cycle pulse at the start of every line. It is given while `de` is low. |
| rd_data_r | input | BYTE_W (8) | Red plane byte, valid one cycle after `rd_req` |
| rd_data_g | input | BYTE_W (8) | Green plane byte, valid one cycle after `rd_req` |
| rd_data_b | input | BYTE_W (8) | Blue plane byte, valid one cycle after `rd_req` |
| rd_req | output | 1 | Byte fetch request to all three planes |
| rd_addr | output | ADDR_W (16) | Byte address of the fetch |
| rgb | output | 3 | Serial pixel colour: red, green, blue |

## Verification
`rd_req` and `rd_addr` are due in the same cycle as the display-enable cycle that triggers them. The bench's plane model returns bytes one cycle after a request, and each pixel is due on `rgb` two cycles after its display-enable cycle. Inputs are driven just after the rising edge, and outputs are sampled at the falling edge. Every expected value comes from a cycle index measured from the start of display-enable, so a pixel is compared in cycle k+2 and a request in cycle k. The row the bench expects is advanced from its own record of which lines carried display-enable, and the plane bytes are a function of address alone.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef logic [2:0] rgb_t;
  localparam int NUM_PLANES = 3;
  localparam int IDX_RED    = 2;
  localparam int IDX_GREEN  = 1;
  localparam int IDX_BLUE   = 0;
endpackage

// File: rtl/bps_fetch_seq.sv
module bps_fetch_seq #(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int BYTE_W   = 8,
  localparam int BPL     = H_ACTIVE / BYTE_W,
  localparam int TOTAL   = BPL * V_ACTIVE,
  localparam int ADDR_W  = $clog2(TOTAL),
  localparam int PH_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1,
  localparam int GRP_W   = $clog2(BPL + 1),
  localparam int ROW_W   = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de,
  input  logic              line_start,
  output logic              req,
  output logic [ADDR_W-1:0] addr
);

  logic [PH_W-1:0]   phase_q, phase_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              seen_q, seen_d;
  logic              row_en;

  // next-state logic
  always_comb begin
    req = de && (phase_q == '0) && (grp_q < GRP_W'(BPL));

    if (!de)                             phase_d = '0;
    else if (phase_q == PH_W'(BYTE_W-1)) phase_d = '0;
    else                                 phase_d = phase_q + 1'b1;

    if (line_start) grp_d = '0;
    else if (req)   grp_d = grp_q + 1'b1;
    else            grp_d = grp_q;

    seen_d = line_start ? 1'b0 : (seen_q | de);

    row_en = line_start && seen_q;
    if (row_q == ROW_W'(V_ACTIVE-1)) begin
      row_d  = '0;
      base_d = '0;
    end else begin
      row_d  = row_q + 1'b1;
      base_d = base_q + ADDR_W'(BPL);
    end
  end

  assign addr = base_q + ADDR_W'(grp_q);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      grp_q   <= '0;
      seen_q  <= 1'b0;
      row_q   <= '0;
      base_q  <= '0;
    end else begin
      phase_q <= phase_d;
      grp_q   <= grp_d;
      seen_q  <= seen_d;
      if (row_en) begin
        row_q  <= row_d;
        base_q <= base_d;
      end
    end
  end

  assert_req_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (32'(addr) < TOTAL));

  assert_row_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(row_q) < V_ACTIVE);

  assert_no_req_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> !req);

endmodule

// File: rtl/bps_piso.sv
module bps_piso #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         dout
);

  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    if (load) sr_d = din;
    else      sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[W-1];

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (dout == $past(din[W-1])));

endmodule

// File: rtl/bitplane_serializer.sv
module bitplane_serializer
  import bps_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int BYTE_W   = 8,
  localparam int BPL     = H_ACTIVE / BYTE_W,
  localparam int ADDR_W  = $clog2(BPL * V_ACTIVE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de,
  input  logic              line_start,
  input  logic [BYTE_W-1:0] rd_data_r,
  input  logic [BYTE_W-1:0] rd_data_g,
  input  logic [BYTE_W-1:0] rd_data_b,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        rgb
);

  logic              load_q;
  logic              de_q1, de_q2;
  logic [BYTE_W-1:0] plane_data [NUM_PLANES];
  rgb_t              plane_bit;

  bps_fetch_seq #(
    .H_ACTIVE (H_ACTIVE),
    .V_ACTIVE (V_ACTIVE),
    .BYTE_W   (BYTE_W)
  ) i_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .de         (de),
    .line_start (line_start),
    .req        (rd_req),
    .addr       (rd_addr)
  );

  // the fetched bytes are present one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      de_q1  <= 1'b0;
      de_q2  <= 1'b0;
    end else begin
      load_q <= rd_req;
      de_q1  <= de;
      de_q2  <= de_q1;
    end
  end

  assign plane_data[IDX_RED]   = rd_data_r;
  assign plane_data[IDX_GREEN] = rd_data_g;
  assign plane_data[IDX_BLUE]  = rd_data_b;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    bps_piso #(.W(BYTE_W)) i_piso (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_q),
      .din   (plane_data[p]),
      .dout  (plane_bit[p])
    );
  end

  assign rgb = plane_bit & {3{de_q2}};

  assert_dark_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(de, 2) |-> (rgb == 3'b000));

endmodule

// File: tb/test_bitplane_serializer.sv
module test_bitplane_serializer;
  localparam int H   = 640;
  localparam int V   = 4;
  localparam int BW  = 8;
  localparam int BPL = H / BW;
  localparam int AW  = $clog2(BPL * V);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          de = 1'b0;
  logic          line_start = 1'b0;
  logic [BW-1:0] dr = '0, dg = '0, db = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [2:0]    rgb;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;
  int cur_row = 0;

  always #4 clk = ~clk;

  bitplane_serializer #(.H_ACTIVE(H), .V_ACTIVE(V), .BYTE_W(BW)) i_bitplane_serializer (
    .clk(clk), .rst_n(rst_n), .de(de), .line_start(line_start),
    .rd_data_r(dr), .rd_data_g(dg), .rd_data_b(db),
    .rd_req(rd_req), .rd_addr(rd_addr), .rgb(rgb)
  );

  function automatic logic [7:0] pat(input int a, input int p);
    int v;
    if (mode == 1) return 8'h00;
    if (mode == 2) return 8'hFF;
    case (p)
      2:       v = a * 7 + 3;
      1:       v = a ^ 8'h96;
      default: v = (a >> 1) + 8'h40 + a * 13;
    endcase
    return v[7:0];
  endfunction

  // plane memories: one cycle read latency
  always @(posedge clk) begin
    if (rd_req) begin
      dr <= pat(int'(rd_addr), 2);
      dg <= pat(int'(rd_addr), 1);
      db <= pat(int'(rd_addr), 0);
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one pixel clock: drive after the rising edge, sample at the falling edge
  task automatic step(input bit ls, input bit d, input int t, input int len, input string rgb_tag);
    bit          exp_req;
    int          exp_addr, k, ea;
    logic [2:0]  exp_rgb;
    logic [7:0]  b;
    @(posedge clk);
    #1;
    line_start = ls;
    de         = d;
    @(negedge clk);
    exp_req  = d && (t >= 0) && (t % BW == 0) && (t / BW < BPL);
    exp_addr = cur_row * BPL + t / BW;
    chk(rd_req == exp_req, "R2", int'(rd_req), int'(exp_req));
    if (exp_req) chk(int'(rd_addr) == exp_addr, "R3", int'(rd_addr), exp_addr);
    k = t - 2;
    exp_rgb = 3'b000;
    if (k >= 0 && k < len && k < H) begin
      ea = cur_row * BPL + k / BW;
      for (int p = 0; p < 3; p++) begin
        b = pat(ea, p);
        exp_rgb[p] = b[BW-1-(k % BW)];
      end
      chk(rgb == exp_rgb, rgb_tag, int'(rgb), int'(exp_rgb));
    end else begin
      chk(rgb == 3'b000, "R6", int'(rgb), 0);
    end
  endtask

  task automatic run_line(input int len, input string rgb_tag);
    step(1'b1, 1'b0, -3, len, rgb_tag);
    step(1'b0, 1'b0, -2, len, rgb_tag);
    step(1'b0, 1'b0, -1, len, rgb_tag);
    for (int t = 0; t < len; t++) step(1'b0, 1'b1, t, len, rgb_tag);
    for (int t = len; t < len + 10; t++) step(1'b0, 1'b0, t, len, rgb_tag);
    if (len > 0) cur_row = (cur_row + 1) % V;
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(rgb == 3'b000, "R1", int'(rgb), 0);
      chk(rd_req == 1'b0, "R1", int'(rd_req), 0);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rgb == 3'b000, "R1", int'(rgb), 0);
    chk(rd_req == 1'b0, "R1", int'(rd_req), 0);
  endtask

  task automatic test_full_lines;   // R4 and R5 with distinct planes
    mode = 0;
    run_line(H, "R4");
    run_line(H, "R5");
    run_line(H, "R5");
  endtask

  task automatic test_blank_line;   // R7: no enable, row kept
    int row_before;
    row_before = cur_row;
    run_line(0, "R7");
    chk(cur_row == row_before, "R7", cur_row, row_before);
    run_line(H, "R7");
  endtask

  task automatic test_row_wrap;     // R7: row V-1 then back to 0
    run_line(H, "R7");
    chk(cur_row == 1, "R7", cur_row, 1);
  endtask

  task automatic test_long_line;    // R2 / R6: enable longer than the visible width
    run_line(H + 60, "R2");
  endtask

  task automatic test_short_line;   // R8: cut line, next starts at group 0
    run_line(100, "R8");
    run_line(H, "R8");
  endtask

  task automatic test_black_white;  // R9
    mode = 1;
    run_line(H, "R9");
    mode = 2;
    run_line(H, "R9");
    mode = 0;
  endtask

  initial begin
    test_reset();
    test_full_lines();
    test_blank_line();
    test_row_wrap();
    test_long_line();
    test_short_line();
    test_black_white();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule